// File: doc/BRIEF.md
# Seconds Prescaler Drift Trimmer

This block divides a real-time tick into a one-second strobe and corrects oscillator drift. At fixed seconds boundaries it shortens or lengthens one second by a small, even number of ticks. A second is shortened by letting the prescaler advance two counts per tick for a while. It is lengthened by freezing the prescaler for a number of ticks. The size and sign of the correction and how often it is applied come from an 8-bit trim word that software writes through a single write strobe.

A written word is held as pending, and `busy_o` rises. At the next boundary where the seconds count reaches 0, 20 or 40, the pending word becomes the active word and `busy_o` drops. While `busy_o` is high, further writes are dropped. Software therefore polls `busy_o` before each write, and `busy_o` is the only flow control. There is no data stream and no back-pressure: `tick_i` is a plain enable, and `sec_pulse_o` is a single-cycle strobe that nothing can stall.

`TICKS_PER_SEC` must be at least 256, so that the largest correction fits inside one second.

Top module: `rtc_trim_unit`

## Requirements
- R1: While reset is asserted and right after it, `sec_pulse_o` and `busy_o` are 0, and the active trim word is zero, so no correction is applied.
- R2: An uncorrected second lasts exactly `TICKS_PER_SEC` ticks. Cycles with `tick_i` low change nothing, so the length counts ticks and not clock cycles.
- R3: Add mode uses trim word bit 6 = 0 and a magnitude m in bits 5:0. For m from 2 to 63, a corrected second is shortened by 2*(m-1) ticks. For m of 0 or 1 there is no correction.
- R4: Subtract mode uses bit 6 = 1. For m not 0, a corrected second is lengthened by 2*(((~m) & 63) + 1) ticks, so m = 63 gives 2 ticks and m = 1 gives 126 ticks. For m = 0 there is no correction.
- R5: With bit 7 = 0, the corrected seconds are those whose seconds count (0 to 59 since reset) is 0, 20 or 40.
- R6: With bit 7 = 1, only the second whose count is 0 is corrected.
- R7: A write while `busy_o` is 0 is accepted, and `busy_o` is 1 from the next cycle. A write while `busy_o` is 1 is ignored and has no effect on any later second. `busy_o` rises only after an accepted write.
- R8: A pending word becomes active at the next strobe that starts a second numbered 0, 20 or 40. It already governs that second. `busy_o` falls in the same cycle as that strobe.
- R9: `sec_pulse_o` is one cycle wide, never high in two cycles in a row, and only follows a cycle with `tick_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One real-time tick when high |
| wr_en_i | input | 1 | Trim word write strobe |
| wr_data_i | input | 8 | Trim word: bit 7 long interval, bit 6 subtract, bits 5:0 magnitude |
| sec_pulse_o | output | 1 | One-cycle strobe at each second boundary |
| busy_o | output | 1 | A written word is waiting for its boundary |

## Verification
The bench first runs with no correction. It then writes, in turn, a short-interval add word, a long-interval subtract word of the smallest size, and a short-interval subtract of the largest size. It follows with the largest add, an add of magnitude 1, and a subtract of magnitude 0. The length in ticks of every second is compared with a queued expectation. This separates add from subtract, the 20 s from the 60 s boundary set, and the magnitude end points from the zero-correction codes. A write made while busy uses a magnitude that would visibly change second 20, which shows whether it was dropped. A stretch of seconds with gapped ticks separates counting ticks from counting clock cycles.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam int MAG_W   = 6;
  localparam int PULSE_W = MAG_W + 1;

  typedef struct packed {
    logic             long_iv;
    logic             sub;
    logic [MAG_W-1:0] mag;
  } trim_word_t;

  // Ticks moved per corrected second: two per step.
  function automatic logic [PULSE_W-1:0] trim_pulses(trim_word_t w);
    logic [MAG_W-1:0] steps;
    if (w.sub) steps = (w.mag != '0) ? (~w.mag) + MAG_W'(1) : '0;
    else       steps = (w.mag > MAG_W'(1)) ? w.mag - MAG_W'(1) : '0;
    return {steps, 1'b0};
  endfunction
endpackage

// File: rtl/trim_decode.sv
module trim_decode
  import rtc_trim_pkg::*;
(
  input  trim_word_t         word_i,
  output logic [PULSE_W-1:0] pulses_o,
  output logic               sub_o,
  output logic               long_iv_o
);
  always_comb begin
    pulses_o  = trim_pulses(word_i);
    sub_o     = word_i.sub;
    long_iv_o = word_i.long_iv;
  end
endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import rtc_trim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  trim_word_t wr_word_i,
  input  logic       bnd_evt_i,
  output trim_word_t eff_word_o,
  output logic       busy_o
);
  trim_word_t pend_q, act_q;
  logic       busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (bnd_evt_i) begin
        act_q  <= pend_q;
        busy_q <= 1'b0;
      end
    end else if (wr_en_i) begin
      pend_q <= wr_word_i;
      busy_q <= 1'b1;
    end
  end

  // The word loaded at a boundary already governs the second it opens.
  assign eff_word_o = busy_q ? pend_q : act_q;
  assign busy_o     = busy_q;
endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SECS_PER_MIN  = 60,
  parameter int SHORT_IV      = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [PULSE_W-1:0] pulses_i,
  input  logic               sub_i,
  input  logic               long_iv_i,
  output logic               bnd_evt_o,
  output logic               sec_pulse_o
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam int SW = $clog2(SECS_PER_MIN);

  logic [CW-1:0]      cnt_q;
  logic [SW-1:0]      sec_q, sec_nx;
  logic [PULSE_W-1:0] rem_q;
  logic               rem_sub_q, pulse_q;
  logic [1:0]         inc;
  logic [CW:0]        sum;
  logic               wrap, short_bnd, long_bnd, apply;

  always_comb begin
    if (rem_q == '0)    inc = 2'd1;
    else if (rem_sub_q) inc = 2'd0;
    else                inc = 2'd2;
    sum       = {1'b0, cnt_q} + (CW+1)'(inc);
    wrap      = tick_i && (sum >= (CW+1)'(TICKS_PER_SEC));
    sec_nx    = (sec_q == SW'(SECS_PER_MIN - 1)) ? '0 : sec_q + SW'(1);
    short_bnd = ((32'(sec_nx) % SHORT_IV) == 0);
    long_bnd  = (sec_nx == '0);
    bnd_evt_o = wrap && short_bnd;
    apply     = bnd_evt_o && (!long_iv_i || long_bnd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sec_q     <= '0;
      rem_q     <= '0;
      rem_sub_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      pulse_q <= wrap;
      if (tick_i) begin
        if (wrap) begin
          cnt_q     <= CW'(sum - (CW+1)'(TICKS_PER_SEC));
          sec_q     <= sec_nx;
          rem_q     <= apply ? pulses_i : '0;
          rem_sub_q <= sub_i;
        end else begin
          cnt_q <= sum[CW-1:0];
          if (rem_q != '0) rem_q <= rem_q - PULSE_W'(1);
        end
      end
    end
  end

  assign sec_pulse_o = pulse_q;
endmodule

// File: rtl/rtc_trim_unit.sv
module rtc_trim_unit
  import rtc_trim_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic       sec_pulse_o,
  output logic       busy_o
);
  trim_word_t         eff_word;
  logic [PULSE_W-1:0] pulses;
  logic               sub, long_iv, bnd_evt;

  trim_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_word_i(trim_word_t'(wr_data_i)),
    .bnd_evt_i(bnd_evt), .eff_word_o(eff_word), .busy_o(busy_o)
  );

  trim_decode u_dec (
    .word_i(eff_word), .pulses_o(pulses), .sub_o(sub), .long_iv_o(long_iv)
  );

  trim_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pulses_i(pulses), .sub_i(sub),
    .long_iv_i(long_iv), .bnd_evt_o(bnd_evt), .sec_pulse_o(sec_pulse_o)
  );
endmodule

// File: rtl/rtc_trim_chk.sv
module rtc_trim_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic wr_en,
  input logic sec_pulse,
  input logic busy
);
  // R9
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> $past(tick));
  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);
  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));
  // R7
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en) |=> !busy);
  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sec_pulse);
endmodule

bind rtc_trim_unit rtc_trim_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_i), .wr_en(wr_en_i),
  .sec_pulse(sec_pulse_o), .busy(busy_o)
);

// File: tb/tb_rtc_trim_unit.sv
module tb_rtc_trim_unit;
  localparam int TPS = 256;
  localparam int NSEC = 222;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic sec_pulse, busy;

  int checks = 0, errors = 0, sec_seen = 0, tick_cnt = 0, cyc = 0;
  bit run = 0, gap = 0, prev_pulse = 0, done = 0;
  int exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  rtc_trim_unit #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .sec_pulse_o(sec_pulse), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic write_word(input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // Tick source; a gapped pattern is used for part of the run (R2)
  always @(posedge clk) begin
    cyc++;
    #1;
    tick = run && (!gap || (cyc % 3) != 0);
  end

  // Monitor: measures each second in ticks and pops the expectation
  always @(negedge clk) begin
    if (rst_n) begin
      if (sec_pulse) begin
        chk(!prev_pulse, "R9", "strobe high two cycles", 1, 0);
        if (exp_q.size() != 0) begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(tick_cnt == e, t, $sformatf("length of second %0d", sec_seen), tick_cnt, e);
        end
        sec_seen++;
        tick_cnt = tick ? 1 : 0;
      end else begin
        tick_cnt += tick ? 1 : 0;
      end
      prev_pulse = sec_pulse;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", sec_seen, NSEC);
    finish_run();
  end

  initial begin
    for (int g = 0; g < NSEC; g++) begin
      int len;
      string t;
      len = TPS; t = "R2";
      if (g == 20 || g == 40)        begin len = TPS - 8;   t = "R3 R5 R7"; end
      else if (g == 60 || g == 120)  begin len = TPS + 2;   t = "R4 R6 R8"; end
      else if (g == 80 || g == 100)  begin len = TPS;       t = "R6"; end
      else if (g == 140 || g == 160) begin len = TPS + 126; t = "R4 R5"; end
      else if (g == 180)             begin len = TPS - 124; t = "R3"; end
      else if (g == 200)             begin len = TPS;       t = "R3 add m=1"; end
      else if (g == 220)             begin len = TPS;       t = "R4 sub m=0"; end
      exp_q.push_back(len);
      tag_q.push_back(t);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sec_pulse == 1'b0, "R1", "strobe in reset", int'(sec_pulse), 0);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    @(posedge clk); #1;
    rst_n = 1'b1; run = 1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);

    repeat (4) @(posedge clk);
    write_word(8'h05);                 // 20 s, add, m=5 -> 8 ticks
    @(negedge clk);
    chk(busy == 1'b1, "R7", "busy after accepted write", int'(busy), 1);
    write_word(8'h3F);                 // dropped: would give -124 at second 20
    wait (sec_seen == 19);
    @(negedge clk);
    chk(busy == 1'b1, "R8", "busy before boundary", int'(busy), 1);
    wait (sec_seen == 21);
    @(negedge clk);
    chk(busy == 1'b0, "R8", "busy after boundary", int'(busy), 0);

    wait (sec_seen == 45);
    write_word(8'hFF);                 // 60 s, subtract, m=63 -> 2 ticks
    wait (sec_seen == 59);
    @(negedge clk);
    chk(busy == 1'b1, "R8", "busy before 60 s load", int'(busy), 1);
    wait (sec_seen == 61);
    @(negedge clk);
    chk(busy == 1'b0, "R8", "busy after 60 s load", int'(busy), 0);

    wait (sec_seen == 100);
    gap = 1;
    wait (sec_seen == 110);
    gap = 0;

    wait (sec_seen == 121);
    write_word(8'h41);                 // 20 s, subtract, m=1 -> 126 ticks
    wait (sec_seen == 161);
    write_word(8'h3F);                 // 20 s, add, m=63 -> 124 ticks
    wait (sec_seen == 181);
    write_word(8'h01);                 // add, m=1 -> none
    wait (sec_seen == 201);
    write_word(8'h40);                 // subtract, m=0 -> none

    wait (exp_q.size() == 0);
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule